// File: doc/BRIEF.md
# Smart Card Contact Control Register

This block is a processor-visible control and status register for the five contacts of a contact smart card: reset, serial I/O, clock and two auxiliary lines. Software writes one register to set the reset line, the I/O direction and value, the auxiliary outputs and the clock parking controls. Reading the same register returns the control bits together with the contact levels, brought into the system clock domain.

A two-bit mode input selects between three modes. In normal mode an external activation sequencer can also hold the card in reset. In bypass mode software drives the I/O and clock contacts directly. In synchronous-card mode the reset line becomes active-high, and the I/O read bit returns the level captured at the last rising card-clock edge.

The card clock comes from an internal divider and is registered before it reaches the pad. It can be parked at a programmable level. Parking starts and ends only on a cycle where the divider level already equals the park level, so the card never receives a shortened clock phase.

Top module: `sc_contact_ctl`

## Requirements
- R1: With `mode_sel` 00 or 11 (normal), one cycle after the inputs are applied `card_rst_o` is 0 whenever control bit 0 (reset field) is 1 or `seq_rst_req` is 1, and 1 otherwise.
- R2: With `mode_sel` 01 (bypass), one cycle later `card_rst_o` is the inverse of the reset field, and `seq_rst_req` has no effect.
- R3: With `mode_sel` 10 (synchronous), one cycle later `card_rst_o` equals the reset field, and `seq_rst_req` has no effect.
- R4: Control bit 1 (I/O direction) resets to 1, meaning input. `card_io_oe` is 1 only in bypass or synchronous mode with the direction bit at 0, and it is never 1 in normal mode.
- R5: `card_io_o` carries control bit 2 (the written I/O value), one cycle after the write.
- R6: In synchronous mode, read bit 2 returns the synchronized I/O pin level captured at the most recent rising edge of `card_clk_o`. It holds that value while the clock is parked.
- R7: Outside synchronous mode, read bit 2 returns the I/O pin through a two-flop synchronizer. A pin change appears on `reg_rdata` exactly three clock edges later.
- R8: For auxiliary contact i (control bit 3+i), when `aux_dir_i[i]` is 1 (output), `card_aux_oe[i]` is 1, `card_aux_o[i]` carries the stored bit, and read bit 3+i returns the stored bit.
- R9: When `aux_dir_i[i]` is 0 (input), `card_aux_oe[i]` is 0, read bit 3+i returns the synchronized `card_aux_i[i]`, and a write still updates the stored bit. After system reset both auxiliary contacts are inputs.
- R10: Outside bypass mode, control bit 6 (clock off) at 1 holds `card_clk_o` at control bit 5 (clock level, 1 = high). At 0 the card clock follows `div_clk_i`, delayed by one register.
- R11: The park state changes only on a cycle where `div_clk_i` equals the clock level, so `card_clk_o` equals the park level on the cycle of every park entry or exit.
- R12: In bypass mode `card_clk_o` equals the clock-level bit one cycle later, and the clock-off bit is ignored.
- R13: The register is 7 bits wide with a one-cycle registered read. Its reset value is 0x46: reset field 0, I/O direction 1, I/O value 1, auxiliary bits 0, clock level 0, clock off 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Registered read data |
| mode_sel | input | 2 | 00/11 normal, 01 bypass, 10 synchronous |
| div_clk_i | input | 1 | Card clock level from the divider |
| seq_rst_req | input | 1 | Reset request from the activation sequencer (1 = hold in reset) |
| aux_dir_i | input | 2 | Auxiliary contact directions (1 = output) |
| card_rst_o | output | 1 | Card reset contact |
| card_io_o | output | 1 | I/O pad output value |
| card_io_oe | output | 1 | I/O pad output enable |
| card_io_i | input | 1 | I/O pad input |
| card_clk_o | output | 1 | Card clock contact |
| card_aux_o | output | 2 | Auxiliary pad output values |
| card_aux_oe | output | 2 | Auxiliary pad output enables |
| card_aux_i | input | 2 | Auxiliary pad inputs |

## Verification
A wrong park state shows up at `card_clk_o` within one clock edge. Either the clock keeps running while it should be parked, or it freezes at the wrong level, or it changes level while `div_clk_i` differs from the park level. A stale synchronous-mode capture or a wrong synchronizer stage count puts the wrong value in read bit 2, one edge earlier or later than the three-edge latency, so the bench compares every output against a behavioural model on every cycle. Reset-polarity errors between modes appear on `card_rst_o` one edge after the mode changes.

// File: rtl/sc_contact_pkg.sv
package sc_contact_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BYPASS = 2'b01,
    MODE_SYNC   = 2'b10,
    MODE_ALT    = 2'b11
  } sc_mode_e;

  localparam int unsigned AUX_N    = 2;
  localparam int unsigned F_RST    = 0;
  localparam int unsigned F_IODIR  = 1;
  localparam int unsigned F_IOVAL  = 2;
  localparam int unsigned F_AUX0   = 3;
  localparam int unsigned F_CLKLVL = F_AUX0 + AUX_N;
  localparam int unsigned F_CLKOFF = F_CLKLVL + 1;
  localparam int unsigned REG_W    = F_CLKOFF + 1;

  localparam logic [REG_W-1:0] CTL_RST_VAL =
    REG_W'((1 << F_IODIR) | (1 << F_IOVAL) | (1 << F_CLKOFF));
endpackage

// File: rtl/sc_pin_sync.sv
module sc_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sc_clk_park.sv
module sc_clk_park (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic div_clk,
  input  logic park_lvl,
  input  logic park_req,
  output logic card_clk,
  output logic parked
);
  // The park state moves only when the divider already sits at the park level.
  always_ff @(posedge clk) begin
    if (rst) begin
      parked   <= 1'b1;
      card_clk <= 1'b0;
    end else begin
      if (div_clk == park_lvl) parked <= park_req;
      if (bypass)      card_clk <= park_lvl;
      else if (parked) card_clk <= park_lvl;
      else             card_clk <= div_clk;
    end
  end
endmodule

// File: rtl/sc_rd_capture.sv
module sc_rd_capture (
  input  logic clk,
  input  logic rst,
  input  logic card_clk,
  input  logic pin,
  output logic cap
);
  logic clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b0;
      cap      <= 1'b0;
    end else begin
      clk_prev <= card_clk;
      if (card_clk && !clk_prev) cap <= pin;
    end
  end
endmodule

// File: rtl/sc_contact_ctl.sv
module sc_contact_ctl
  import sc_contact_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [1:0]       mode_sel,
  input  logic             div_clk_i,
  input  logic             seq_rst_req,
  input  logic [AUX_N-1:0] aux_dir_i,
  output logic             card_rst_o,
  output logic             card_io_o,
  output logic             card_io_oe,
  input  logic             card_io_i,
  output logic             card_clk_o,
  output logic [AUX_N-1:0] card_aux_o,
  output logic [AUX_N-1:0] card_aux_oe,
  input  logic [AUX_N-1:0] card_aux_i
);
  localparam int unsigned PIN_W = 1 + AUX_N;

  sc_mode_e         mode;
  logic             is_byp, is_sync;
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] rd_next;
  logic [PIN_W-1:0] pins_s;
  logic [AUX_N-1:0] aux_oe_q;
  logic [AUX_N-1:0] aux_rd;
  logic             park_q;
  logic             io_cap;

  assign mode    = sc_mode_e'(mode_sel);
  assign is_byp  = (mode == MODE_BYPASS);
  assign is_sync = (mode == MODE_SYNC);

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= CTL_RST_VAL;
    else if (reg_wr) ctl_q <= reg_wdata;
  end

  sc_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({card_aux_i, card_io_i}),
    .q   (pins_s)
  );

  sc_clk_park u_park (
    .clk      (clk),
    .rst      (rst),
    .bypass   (is_byp),
    .div_clk  (div_clk_i),
    .park_lvl (ctl_q[F_CLKLVL]),
    .park_req (ctl_q[F_CLKOFF]),
    .card_clk (card_clk_o),
    .parked   (park_q)
  );

  sc_rd_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .card_clk (card_clk_o),
    .pin      (pins_s[0]),
    .cap      (io_cap)
  );

  // Contact drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      card_rst_o <= 1'b0;
      card_io_o  <= 1'b1;
      card_io_oe <= 1'b0;
      card_aux_o <= '0;
      aux_oe_q   <= '0;
    end else begin
      if (is_sync)     card_rst_o <= ctl_q[F_RST];
      else if (is_byp) card_rst_o <= ~ctl_q[F_RST];
      else             card_rst_o <= ~(ctl_q[F_RST] | seq_rst_req);
      card_io_oe <= (is_byp | is_sync) & ~ctl_q[F_IODIR];
      card_io_o  <= ctl_q[F_IOVAL];
      card_aux_o <= ctl_q[F_AUX0 +: AUX_N];
      aux_oe_q   <= aux_dir_i;
    end
  end

  assign card_aux_oe = aux_oe_q;

  for (genvar g = 0; g < int'(AUX_N); g++) begin : g_aux_rd
    assign aux_rd[g] = aux_oe_q[g] ? ctl_q[F_AUX0 + g] : pins_s[1 + g];
  end

  always_comb begin
    rd_next                    = ctl_q;
    rd_next[F_IOVAL]           = is_sync ? io_cap : pins_s[0];
    rd_next[F_AUX0 +: AUX_N]   = aux_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/sc_contact_ctl_chk.sv
module sc_contact_ctl_chk
  import sc_contact_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic             seq_rst_req,
  input logic [REG_W-1:0] ctl_q,
  input logic             park_q,
  input logic             card_rst_o,
  input logic             card_io_oe,
  input logic             card_clk_o
);
  AST_NORMAL_RST_LOW: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'b00 || mode_sel == 2'b11) && (ctl_q[F_RST] || seq_rst_req)) |=> !card_rst_o); // R1
  AST_BYPASS_RST_INV: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01) |=> (card_rst_o == !$past(ctl_q[F_RST]))); // R2
  AST_SYNC_RST_TRUE: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10) |=> (card_rst_o == $past(ctl_q[F_RST]))); // R3
  AST_NORMAL_IO_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00 || mode_sel == 2'b11) |=> !card_io_oe); // R4
  AST_PARKED_CLK_STEADY: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != 2'b01 && park_q) |=> (card_clk_o == $past(ctl_q[F_CLKLVL]))); // R10
  AST_PARK_EDGE_AT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_sel) != 2'b01 && park_q != $past(park_q)) |-> (card_clk_o == $past(ctl_q[F_CLKLVL]))); // R11
  AST_BYPASS_CLK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01) |=> (card_clk_o == $past(ctl_q[F_CLKLVL]))); // R12
endmodule

bind sc_contact_ctl sc_contact_ctl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_sel    (mode_sel),
  .seq_rst_req (seq_rst_req),
  .ctl_q       (ctl_q),
  .park_q      (park_q),
  .card_rst_o  (card_rst_o),
  .card_io_oe  (card_io_oe),
  .card_clk_o  (card_clk_o)
);

// File: tb/test_sc_contact_ctl.sv
`timescale 1ns/1ps
module test_sc_contact_ctl;
  logic       clk = 0;
  logic       rst = 1;
  logic       reg_wr = 0;
  logic [6:0] reg_wdata = '0;
  logic [6:0] reg_rdata;
  logic [1:0] mode_sel = 2'b00;
  logic       div_clk = 0;
  logic       seq_rst_req = 0;
  logic [1:0] aux_dir = 2'b00;
  logic       card_rst_o, card_io_o, card_io_oe, card_io_i = 1, card_clk_o;
  logic [1:0] card_aux_o, card_aux_oe, card_aux_i = 2'b00;

  int checks = 0, failures = 0, cyc = 0, div_half = 2, div_cnt = 0;
  bit done = 0, started = 0;

  always #10 clk = ~clk;

  sc_contact_ctl i_sc_contact_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mode_sel(mode_sel), .div_clk_i(div_clk), .seq_rst_req(seq_rst_req), .aux_dir_i(aux_dir),
    .card_rst_o(card_rst_o), .card_io_o(card_io_o), .card_io_oe(card_io_oe), .card_io_i(card_io_i),
    .card_clk_o(card_clk_o), .card_aux_o(card_aux_o), .card_aux_oe(card_aux_oe), .card_aux_i(card_aux_i)
  );

  // divider stand-in, driven away from the active edge
  always @(negedge clk) begin
    if (div_cnt >= div_half) begin div_clk <= ~div_clk; div_cnt <= 0; end
    else div_cnt <= div_cnt + 1;
  end

  // behavioural reference model
  bit [6:0] m_ctl, m_rd;
  bit [2:0] m_pq [$];
  bit       m_park, m_clk, m_prev, m_cap, m_rst, m_ioo, m_iooe;
  bit [1:0] m_auxo, m_auxoe;
  bit [2:0] old_s;
  bit       byp, syn, lvl;

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_ctl = 7'h46; m_rd = 0; m_pq = {3'b000, 3'b000};
      m_park = 1; m_clk = 0; m_prev = 0; m_cap = 0;
      m_rst = 0; m_ioo = 1; m_iooe = 0; m_auxo = 0; m_auxoe = 0;
    end else begin
      byp = (mode_sel == 2'b01);
      syn = (mode_sel == 2'b10);
      lvl = m_ctl[5];
      old_s = m_pq[0];
      m_rd = m_ctl;
      m_rd[2] = syn ? m_cap : old_s[0];
      for (int i = 0; i < 2; i++) m_rd[3+i] = m_auxoe[i] ? m_ctl[3+i] : old_s[1+i];
      if (m_clk && !m_prev) m_cap = old_s[0];
      m_prev = m_clk;
      m_clk = (byp || m_park) ? lvl : div_clk;
      if (div_clk == lvl) m_park = m_ctl[6];
      void'(m_pq.pop_front());
      m_pq.push_back({card_aux_i, card_io_i});
      if (syn) m_rst = m_ctl[0];
      else if (byp) m_rst = !m_ctl[0];
      else m_rst = !(m_ctl[0] || seq_rst_req);
      m_iooe = (byp || syn) && !m_ctl[1];
      m_ioo = m_ctl[2];
      m_auxo = m_ctl[4:3];
      m_auxoe = aux_dir;
      if (reg_wr) m_ctl = reg_wdata;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("R1/R2/R3 card_rst_o", card_rst_o, m_rst);
    chk("R4 card_io_oe", card_io_oe, m_iooe);
    chk("R5 card_io_o", card_io_o, m_ioo);
    chk("R10/R11/R12 card_clk_o", card_clk_o, m_clk);
    chk("R8/R9 card_aux_o", card_aux_o, m_auxo);
    chk("R8/R9 card_aux_oe", card_aux_oe, m_auxoe);
    chk("R6/R7/R13 reg_rdata", reg_rdata, m_rd);
  end

  task automatic step(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(bit [6:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  always @(posedge clk) if (cyc > 150000 && !done) begin
    done = 1; failures++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit saw0, saw1;
    step(4); rst = 0; step(4);
    chk("R13 reset read value", reg_rdata, 7'h46);
    chk("R1 released with no request", card_rst_o, 1);
    chk("R4 io input after reset", card_io_oe, 0);
    chk("R9 aux inputs after reset", card_aux_oe, 0);
    seq_rst_req = 1; step(2);
    chk("R1 sequencer request", card_rst_o, 0);
    seq_rst_req = 0; wr(7'h47); step(3);
    chk("R1 field asserts reset", card_rst_o, 0);
    mode_sel = 2'b01; step(2);
    chk("R2 bypass field 1", card_rst_o, 0);
    wr(7'h46); seq_rst_req = 1; step(3);
    chk("R2 bypass ignores sequencer", card_rst_o, 1);
    seq_rst_req = 0; mode_sel = 2'b10; wr(7'h47); step(3);
    chk("R3 sync field 1", card_rst_o, 1);
    wr(7'h46); step(3);
    chk("R3 sync field 0", card_rst_o, 0);
    mode_sel = 2'b00; wr(7'h44); step(3);
    chk("R4 normal never drives io", card_io_oe, 0);
    mode_sel = 2'b01; wr(7'h00); step(3);
    chk("R4 bypass output enable", card_io_oe, 1);
    chk("R5 bypass io value 0", card_io_o, 0);
    wr(7'h04); step(3);
    chk("R5 bypass io value 1", card_io_o, 1);
    wr(7'h64); step(3);
    chk("R12 bypass level high, off ignored", card_clk_o, 1);
    wr(7'h44); step(3);
    chk("R12 bypass level low", card_clk_o, 0);
    // R10 park at high level
    mode_sel = 2'b00; wr(7'h66); step(12);
    saw0 = 0; saw1 = 0;
    repeat (20) begin step(1); if (card_clk_o) saw1 = 1; else saw0 = 1; end
    chk("R10 parked high never low", saw0, 0);
    wr(7'h26); step(12);
    saw0 = 0; saw1 = 0;
    repeat (20) begin step(1); if (card_clk_o) saw1 = 1; else saw0 = 1; end
    chk("R10 running clock toggles", {saw0, saw1}, 2'b11);
    // R7 synchronizer latency in normal mode
    card_io_i = 0; step(2);
    chk("R7 not yet visible after two edges", reg_rdata[2], 1);
    step(1);
    chk("R7 visible after three edges", reg_rdata[2], 0);
    // R6 synchronous capture
    mode_sel = 2'b10; card_io_i = 1; step(30);
    chk("R6 captured io high", reg_rdata[2], 1);
    wr(7'h66); step(20); card_io_i = 0; step(20);
    chk("R6 parked clock holds capture", reg_rdata[2], 1);
    wr(7'h26); step(30);
    chk("R6 capture after restart", reg_rdata[2], 0);
    // R8 / R9 auxiliary contacts
    mode_sel = 2'b00; aux_dir = 2'b11; card_aux_i = 2'b01; wr(7'h16); step(4);
    chk("R8 aux drives stored", card_aux_o, 2'b10);
    chk("R8 aux enables", card_aux_oe, 2'b11);
    chk("R8 aux reads stored", reg_rdata[4:3], 2'b10);
    aux_dir = 2'b00; wr(7'h0E); step(4);
    chk("R9 aux undriven", card_aux_oe, 2'b00);
    chk("R9 aux reads pin", reg_rdata[4:3], 2'b01);
    aux_dir = 2'b11; step(3);
    chk("R9 stored write now driven", card_aux_o, 2'b01);
    // mixed stimulus, model-compared every cycle
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (k % 64 == 0) begin mode_sel = $urandom; div_half = $urandom_range(0, 4); end
      reg_wr = ($urandom_range(0, 9) == 0);
      reg_wdata = $urandom;
      seq_rst_req = $urandom; aux_dir = $urandom;
      card_io_i = $urandom; card_aux_i = $urandom;
    end
    reg_wr = 0; step(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule